// File: doc/BRIEF.md
# Offset-Adjusted Physical Timer Comparator

This block is the compare stage of a physical count/compare timer. It takes a free-running 64-bit system count and subtracts a hypervisor-programmable 64-bit offset. The offset is applied only when four qualifying conditions hold at the same time. The corrected count drives two things: a greater-or-equal comparison against a programmed compare value, which gives the timer status and interrupt, and a read view for software.

The compare logic and the software read path treat the offset differently. The comparator always uses the gated offset. The read path, which covers the count read, the 32-bit remaining-time read and the 32-bit remaining-time write, drops the offset for any access made at privilege level 2 or higher. Access to the offset register is restricted by privilege level. A refused access is flagged on a trap output and leaves the register unchanged.

A simple register port (address, write and read strobes) reaches the offset, the compare value, the remaining-time view, a control word and the corrected count. Read data returns one cycle after the read strobe, qualified by a valid flag.

Top module: `phys_offset_timer`

## Requirements
- R1: The effective offset equals the offset register only while all of these hold: `top_en`, `hyp_ctl_en` and `hyp_present` are 1, and `hyp_host_mode` and `hyp_trap_general` are not both 1. Otherwise the effective offset is zero.
- R2: The count view (`count_view`, and a read at address 4) is raw count minus the effective offset when `priv_level` is 0 or 1, and is the raw count when `priv_level` is 2 or 3.
- R3: `timer_status` is 1 exactly when (raw count − effective offset) ≥ compare value, as unsigned 64-bit arithmetic with wraparound, at every privilege level.
- R4: A read at address 2 returns, zero-extended, the low 32 bits of (compare value − count view).
- R5: A write at address 2 sets the compare value to the count view plus the sign-extended low 32 bits of the write data.
- R6: An access to the offset register (address 0) at privilege level 2 while `top_en` is 0 pulses `access_trap` in the cycle after the access and leaves the register unchanged.
- R7: An access to the offset register at privilege level 0 or 1 pulses `access_trap`. A write is ignored and a read returns zero. Levels 3, and 2 with `top_en` set, access it freely.
- R8: After reset the offset and compare registers are zero. In the cycle after any accepted offset write, `timer_status` already reflects the new offset.
- R9: With parameter `FEATURE_PRESENT` = 0, both enable inputs are treated as 0, so no offset is ever applied.
- R10: The control word at address 3 has bit 0 = timer enable and bit 1 = interrupt mask, both writable, and bit 2 = status, read only. `timer_irq` = status AND enable AND NOT mask, and it changes in the same cycle as the status.
- R11: During and just after reset, `bus_rvalid`, `access_trap` and `timer_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_count | input | 64 | Free-running system count |
| priv_level | input | 2 | Current privilege level, 0 to 3 |
| top_en | input | 1 | Top-level enable for the offset mechanism |
| hyp_ctl_en | input | 1 | Hypervisor control enable for the offset |
| hyp_present | input | 1 | Hypervisor level is implemented and active |
| hyp_host_mode | input | 1 | Hypervisor host-mode bit |
| hyp_trap_general | input | 1 | Hypervisor trap-general bit |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | 0 offset, 1 compare, 2 remaining time, 3 control, 4 count |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| count_view | output | 64 | Privilege-dependent corrected count |
| timer_status | output | 1 | Compare status |
| timer_irq | output | 1 | Interrupt request |
| access_trap | output | 1 | One-cycle pulse for a refused offset access |

## Verification
A wrong gating term or a wrong privilege decode shows at once on `count_view` and `timer_status`. Both are combinational from the registered state, so the error appears in the same cycle that the offending input changes. A corrupted offset or compare register appears in the cycle after the write that caused it, either as a status flip or as a wrong value on the next read. A missed trap shows as `access_trap` staying low one cycle after the access, and as a changed value on a later read of the offset.

// File: rtl/potimer_pkg.sv
package potimer_pkg;
    localparam int CNT_W  = 64;
    localparam int TV_W   = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_OFFSET  = 3'd0,
        A_COMPARE = 3'd1,
        A_TVAL    = 3'd2,
        A_CTRL    = 3'd3,
        A_COUNT   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [CNT_W-1:0] off;
        logic [CNT_W-1:0] cmp;
        logic             en;
        logic             mask;
        logic             rvalid;
        logic [CNT_W-1:0] rdata;
        logic             trap;
    } regs_t;
endpackage

// File: rtl/potimer_gate.sv
module potimer_gate
    import potimer_pkg::*;
#(
    parameter bit FEATURE_PRESENT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             top_en,
    input  logic             hyp_ctl_en,
    input  logic             hyp_present,
    input  logic             hyp_host_mode,
    input  logic             hyp_trap_general,
    input  logic [1:0]       priv_level,
    input  logic [CNT_W-1:0] off_q,
    output logic             top_en_eff,
    output logic [CNT_W-1:0] eff_off,
    output logic [CNT_W-1:0] read_off
);
    logic hyp_en_eff;
    logic gate_on;
    logic high_level;

    generate
        if (FEATURE_PRESENT) begin : g_feat
            assign top_en_eff = top_en;
            assign hyp_en_eff = hyp_ctl_en;
        end else begin : g_nofeat
            assign top_en_eff = 1'b0;
            assign hyp_en_eff = 1'b0;
        end
    endgenerate

    always_comb begin
        gate_on    = top_en_eff && hyp_en_eff && hyp_present &&
                     !(hyp_host_mode && hyp_trap_general);
        high_level = (priv_level >= 2'd2);
        eff_off    = gate_on ? off_q : '0;
        read_off   = high_level ? '0 : eff_off;
    end

    assert_gate_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(top_en && hyp_ctl_en && hyp_present) |-> (eff_off == '0));

    assert_high_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_level[1]) |-> (read_off == '0));

    assert_nofeat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!FEATURE_PRESENT) |-> (eff_off == '0));
endmodule

// File: rtl/potimer_cmp.sv
module potimer_cmp
    import potimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] raw_count,
    input  logic [CNT_W-1:0] eff_off,
    input  logic [CNT_W-1:0] read_off,
    input  logic [CNT_W-1:0] cmp_q,
    input  logic             en_q,
    input  logic             mask_q,
    output logic             status,
    output logic             irq,
    output logic [CNT_W-1:0] read_count,
    output logic [TV_W-1:0]  tval_view
);
    logic [CNT_W-1:0] cmp_count;
    logic [CNT_W-1:0] remain;

    always_comb begin
        cmp_count  = raw_count - eff_off;
        read_count = raw_count - read_off;
        status     = (cmp_count >= cmp_q);
        remain     = cmp_q - read_count;
        tval_view  = remain[TV_W-1:0];
        irq        = status && en_q && !mask_q;
    end

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status && en_q && !mask_q));

    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q || !en_q) |-> !irq);
endmodule

// File: rtl/potimer_regs.sv
module potimer_regs
    import potimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic [1:0]        priv_level,
    input  logic              top_en_eff,
    input  logic [CNT_W-1:0]  read_count,
    input  logic [TV_W-1:0]   tval_view,
    input  logic              status,
    output logic [CNT_W-1:0]  off_q,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              en_q,
    output logic              mask_q,
    output logic              rvalid_q,
    output logic [CNT_W-1:0]  rdata_q,
    output logic              trap_q
);
    localparam int EXT_W = CNT_W - TV_W;

    regs_t     s_d, s_q;
    reg_addr_e addr;
    logic      off_access;
    logic      violation;
    logic [CNT_W-1:0] wdata_sext;

    always_comb begin
        addr       = reg_addr_e'(bus_addr);
        off_access = (bus_wr || bus_rd) && (addr == A_OFFSET);
        violation  = off_access &&
                     ((priv_level < 2'd2) || (priv_level == 2'd2 && !top_en_eff));
        wdata_sext = {{EXT_W{bus_wdata[TV_W-1]}}, bus_wdata[TV_W-1:0]};

        s_d        = s_q;
        s_d.rvalid = bus_rd;
        s_d.trap   = violation;

        if (bus_wr && !violation) begin
            case (addr)
                A_OFFSET:  s_d.off = bus_wdata;
                A_COMPARE: s_d.cmp = bus_wdata;
                A_TVAL:    s_d.cmp = read_count + wdata_sext;
                A_CTRL: begin
                    s_d.en   = bus_wdata[0];
                    s_d.mask = bus_wdata[1];
                end
                default: ;
            endcase
        end

        if (bus_rd) begin
            s_d.rdata = '0;
            case (addr)
                A_OFFSET:  s_d.rdata = violation ? '0 : s_q.off;
                A_COMPARE: s_d.rdata = s_q.cmp;
                A_TVAL:    s_d.rdata = {{EXT_W{1'b0}}, tval_view};
                A_CTRL:    s_d.rdata[2:0] = {status, s_q.mask, s_q.en};
                A_COUNT:   s_d.rdata = read_count;
                default:   s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign off_q    = s_q.off;
    assign cmp_q    = s_q.cmp;
    assign en_q     = s_q.en;
    assign mask_q   = s_q.mask;
    assign rvalid_q = s_q.rvalid;
    assign rdata_q  = s_q.rdata;
    assign trap_q   = s_q.trap;

    assert_trap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> $stable(off_q));

    assert_low_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && !priv_level[1]) |=> (trap_q && $stable(off_q)));

    assert_rvalid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> rvalid_q);
endmodule

// File: rtl/phys_offset_timer.sv
module phys_offset_timer
    import potimer_pkg::*;
#(
    parameter bit FEATURE_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  raw_count,
    input  logic [1:0]        priv_level,
    input  logic              top_en,
    input  logic              hyp_ctl_en,
    input  logic              hyp_present,
    input  logic              hyp_host_mode,
    input  logic              hyp_trap_general,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    output logic [CNT_W-1:0]  count_view,
    output logic              timer_status,
    output logic              timer_irq,
    output logic              access_trap
);
    logic [CNT_W-1:0] off_q, cmp_q, eff_off, read_off, read_count;
    logic [TV_W-1:0]  tval_view;
    logic             en_q, mask_q, top_en_eff, status, irq;

    potimer_gate #(.FEATURE_PRESENT(FEATURE_PRESENT)) gate_i (
        .clk(clk), .rst_n(rst_n),
        .top_en(top_en), .hyp_ctl_en(hyp_ctl_en), .hyp_present(hyp_present),
        .hyp_host_mode(hyp_host_mode), .hyp_trap_general(hyp_trap_general),
        .priv_level(priv_level), .off_q(off_q),
        .top_en_eff(top_en_eff), .eff_off(eff_off), .read_off(read_off)
    );

    potimer_cmp cmp_i (
        .clk(clk), .rst_n(rst_n),
        .raw_count(raw_count), .eff_off(eff_off), .read_off(read_off),
        .cmp_q(cmp_q), .en_q(en_q), .mask_q(mask_q),
        .status(status), .irq(irq), .read_count(read_count), .tval_view(tval_view)
    );

    potimer_regs regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .priv_level(priv_level), .top_en_eff(top_en_eff),
        .read_count(read_count), .tval_view(tval_view), .status(status),
        .off_q(off_q), .cmp_q(cmp_q), .en_q(en_q), .mask_q(mask_q),
        .rvalid_q(bus_rvalid), .rdata_q(bus_rdata), .trap_q(access_trap)
    );

    assign count_view   = read_count;
    assign timer_status = status;
    assign timer_irq    = irq;
endmodule

// File: tb/phys_offset_timer_tb_top.sv
module phys_offset_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] raw_count = 64'd2000;
    logic [1:0]  priv_level = 2'd3;
    logic        top_en = 1'b1, hyp_ctl_en = 1'b1, hyp_present = 1'b1;
    logic        hyp_host_mode = 1'b0, hyp_trap_general = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata, count_view, rdata2, count2;
    logic        bus_rvalid, timer_status, timer_irq, access_trap;
    logic        rvalid2, status2, irq2, trap2;

    int checks = 0;
    int fails  = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    phys_offset_timer dut_i (
        .clk(clk), .rst_n(rst_n), .raw_count(raw_count), .priv_level(priv_level),
        .top_en(top_en), .hyp_ctl_en(hyp_ctl_en), .hyp_present(hyp_present),
        .hyp_host_mode(hyp_host_mode), .hyp_trap_general(hyp_trap_general),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .count_view(count_view),
        .timer_status(timer_status), .timer_irq(timer_irq), .access_trap(access_trap)
    );

    phys_offset_timer #(.FEATURE_PRESENT(1'b0)) nofeat_i (
        .clk(clk), .rst_n(rst_n), .raw_count(raw_count), .priv_level(priv_level),
        .top_en(top_en), .hyp_ctl_en(hyp_ctl_en), .hyp_present(hyp_present),
        .hyp_host_mode(hyp_host_mode), .hyp_trap_general(hyp_trap_general),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata2), .bus_rvalid(rvalid2), .count_view(count2),
        .timer_status(status2), .timer_irq(irq2), .access_trap(trap2)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R11 unexpected read data actual=0x%0h expected=none", bus_rdata);
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd_reg(input logic [2:0] a, input logic [63:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        #1;
        chk({63'd0, bus_rvalid | access_trap | timer_irq}, 64'd0, "R11 outputs in reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk({63'd0, bus_rvalid | access_trap | timer_irq}, 64'd0, "R11 outputs after reset");
        rd_reg(3'd0, 64'd0, "R8 offset reset value");
        rd_reg(3'd1, 64'd0, "R8 compare reset value");

        wr_reg(3'd1, 64'd1500);
        chk({63'd0, timer_status}, 64'd1, "R3 status without offset");
        wr_reg(3'd0, 64'd600);
        chk({63'd0, timer_status}, 64'd0, "R8 status right after offset write");
        chk({63'd0, access_trap}, 64'd0, "R7 level 3 offset write no trap");

        priv_level = 2'd1; #1;
        chk(count_view, 64'd1400, "R2 level 1 count view");
        rd_reg(3'd4, 64'd1400, "R2 level 1 count read");
        chk({63'd0, timer_status}, 64'd0, "R3 status at level 1");
        priv_level = 2'd2; #1;
        chk(count_view, 64'd2000, "R2 level 2 count view");
        chk({63'd0, timer_status}, 64'd0, "R3 status at level 2 keeps offset");

        priv_level = 2'd1;
        hyp_host_mode = 1'b1; hyp_trap_general = 1'b1; #1;
        chk(count_view, 64'd2000, "R1 both mode bits set");
        chk({63'd0, timer_status}, 64'd1, "R1 status with offset gated off");
        hyp_trap_general = 1'b0; #1;
        chk(count_view, 64'd1400, "R1 only host mode");
        hyp_host_mode = 1'b0; hyp_present = 1'b0; #1;
        chk(count_view, 64'd2000, "R1 hypervisor absent");
        hyp_present = 1'b1; hyp_ctl_en = 1'b0; #1;
        chk(count_view, 64'd2000, "R1 control enable clear");
        hyp_ctl_en = 1'b1; top_en = 1'b0; #1;
        chk(count_view, 64'd2000, "R1 top enable clear");
        top_en = 1'b1; #1;

        rd_reg(3'd2, 64'd100, "R4 level 1 remaining time");
        priv_level = 2'd2;
        rd_reg(3'd2, 64'h0000_0000_FFFF_FE0C, "R4 level 2 remaining time wraps");

        priv_level = 2'd1;
        wr_reg(3'd2, 64'h0000_0000_FFFF_FF9C);
        chk({63'd0, timer_status}, 64'd1, "R5 negative remaining time status");
        priv_level = 2'd3;
        rd_reg(3'd1, 64'd1300, "R5 sign-extended write at level 1");
        priv_level = 2'd2;
        wr_reg(3'd2, 64'h0000_0000_0000_0032);
        rd_reg(3'd1, 64'd2050, "R5 write at level 2 ignores offset");
        chk({63'd0, timer_status}, 64'd0, "R3 status below compare");

        raw_count = 64'd100; #1;
        chk({63'd0, timer_status}, 64'd1, "R3 unsigned wrap when offset exceeds count");
        raw_count = 64'd2000; #1;

        priv_level = 2'd2; top_en = 1'b0;
        wr_reg(3'd0, 64'd7);
        chk({63'd0, access_trap}, 64'd1, "R6 level 2 trap with top enable clear");
        top_en = 1'b1; priv_level = 2'd3;
        rd_reg(3'd0, 64'd600, "R6 offset unchanged after trap");
        chk({63'd0, access_trap}, 64'd0, "R6 trap is one pulse");
        priv_level = 2'd2;
        wr_reg(3'd0, 64'd600);
        chk({63'd0, access_trap}, 64'd0, "R6 level 2 with top enable set");

        priv_level = 2'd1;
        wr_reg(3'd0, 64'd9);
        chk({63'd0, access_trap}, 64'd1, "R7 level 1 write traps");
        priv_level = 2'd0;
        rd_reg(3'd0, 64'd0, "R7 level 0 read returns zero");
        chk({63'd0, access_trap}, 64'd1, "R7 level 0 read traps");
        priv_level = 2'd3;
        rd_reg(3'd0, 64'd600, "R7 offset unchanged after low-level write");

        wr_reg(3'd1, 64'd1000);
        chk({63'd0, timer_irq}, 64'd0, "R10 irq off while disabled");
        wr_reg(3'd3, 64'd1);
        chk({63'd0, timer_irq}, 64'd1, "R10 irq on when enabled");
        rd_reg(3'd3, 64'd5, "R10 control word read");
        wr_reg(3'd3, 64'd3);
        chk({63'd0, timer_irq}, 64'd0, "R10 irq masked");
        wr_reg(3'd3, 64'd1);
        wr_reg(3'd0, 64'd1500);
        chk({62'd0, timer_status, timer_irq}, 64'd0, "R10 irq drops with status");

        priv_level = 2'd1; #1;
        chk(count2, 64'd2000, "R9 feature absent applies no offset");
        chk(count_view, 64'd500, "R9 feature present applies offset");
        chk({63'd0, status2}, 64'd1, "R9 feature absent status");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R11 reads missing actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule